// File: doc/BRIEF.md
# General-Purpose Pin Controller with Edge Interrupts

This block controls three bidirectional general-purpose pins and two output-only pins. The host reaches every setting and value through a small register port. Each bidirectional pin runs in one of three modes: it can be an input, it can drive both levels, or it can only pull low. The output-only pins always drive the value the host last wrote to them. The pad cells sit outside the block. Each pin is therefore modelled here as an output value, an output enable and an input level.

Each bidirectional pin goes through a two-flop synchronizer before the block uses its level. The block compares the synchronized level with its value one cycle earlier to find edges. A per-pin polarity bit picks whether a rising or a falling edge latches that pin's status bit. The host clears a status bit by writing 1 to it. The one interrupt request is the OR of the status bits whose enable bit is set.

Register map (2-bit address):
- Address 0, configuration. Bits [2i+1:2i] hold the mode of pin i. Bit 8+i holds the polarity of pin i. Bit 12+i holds the interrupt enable of pin i. The full 32-bit word reads back as written.
- Address 1, data. A write sets the pin output values from bits [2:0] and the output-only pin values from bits [4:3]. A read returns the synchronized levels in [2:0], the output-only pin values in [4:3] and the pin output values in [10:8].
- Address 2, interrupt status, in bits [2:0].
- Address 3 reads as zero.

Top module: `gpio_ctrl`

## Requirements
- R1: After a synchronous active-low reset, every output enable, pin output, output-only pin and the interrupt request are 0, and the status register reads 0.
- R2: A pin whose mode code is 00 or 11 is an input: its output enable and output value are 0.
- R3: A pin whose mode code is 01 drives both levels: its output enable is 1 and its output value equals its data bit.
- R4: A pin whose mode code is 10 only pulls low: its output value is 0 and its output enable equals the inverse of its data bit.
- R5: The output-only pins show data-register bits [4:3], take effect right after the write, and change only when the data register is written. Configuration writes do not affect them.
- R6: Data-register read bits [2:0] show each pin's input level two clock edges after the level changes, whatever the pin's mode.
- R7: A status bit is set three clock edges after a matching edge at the pin. Polarity 1 selects a rising edge and 0 a falling edge. An edge of the other direction sets nothing.
- R8: Writing 1 to a status bit clears it. Writing 0 leaves it unchanged.
- R9: If an edge would set a status bit in the same cycle that a write clears it, the bit ends up set.
- R10: A status bit latches whether or not its enable is set. The interrupt request is high exactly when some status bit is set and its enable bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address for both reads and writes |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| gpio_in | input | 3 | Pin levels coming from the pads |
| gpio_out | output | 3 | Pin output values |
| gpio_oe | output | 3 | Pin output enables |
| gpo_out | output | 2 | Output-only pin values |
| irq | output | 1 | Interrupt request |

## Verification
The assertions run on every cycle. They check that the synchronizer delays by exactly two edges and that a status bit can rise only after a synchronized edge of the selected direction. They also check that an edge always sets a status bit, even when a clear is requested in the same cycle, and that a clear with no edge takes effect. A pull-low pin must never drive high, and the output-only pins may change only after a data write. Other behaviour can only be shown by the bench's scenarios. These are the mode-by-mode output tables, the exact cycle at which a status bit appears, the fact that writing 0 to a status bit leaves it alone, and the effect of the enable bits on the interrupt request.

// File: rtl/gpio_pkg.sv
// Shared types and register addresses for the pin controller.
package gpio_pkg;
    typedef enum logic [1:0] {
        PM_INPUT     = 2'b00,
        PM_PUSHPULL  = 2'b01,
        PM_OPENDRAIN = 2'b10,
        PM_INPUT_ALT = 2'b11
    } pin_mode_e;

    localparam logic [1:0] ADDR_CFG    = 2'd0;
    localparam logic [1:0] ADDR_DATA   = 2'd1;
    localparam logic [1:0] ADDR_STATUS = 2'd2;
endpackage

// File: rtl/gpio_sync.sv
// Multi-stage synchronizer for asynchronous pin levels.
// Assumes each bit is an independent level; no bus coherency is implied.
module gpio_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] chain_q [STAGES];

    // Shift the input through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) chain_q[s] <= '0;
        end else begin
            chain_q[0] <= din;
            for (int s = 1; s < STAGES; s++) chain_q[s] <= chain_q[s-1];
        end
    end

    assign dout = chain_q[STAGES-1];

    generate
        if (STAGES == 2) begin : g_chk
            // R6: the output equals the input from two edges earlier
            assert_sync_delay_R6: assert property (@(posedge clk) disable iff (!rst_n)
                $past(rst_n, 2) |-> dout == $past(din, 2));
        end
    endgenerate
endmodule

// File: rtl/gpio_pin.sv
// One bidirectional pin: mode-dependent drive and edge-triggered status.
// Assumes pin_sync is already synchronized to clk.
module gpio_pin
    import gpio_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  pin_mode_e mode,
    input  logic      data_bit,
    input  logic      polarity,
    input  logic      clr,
    input  logic      pin_sync,
    output logic      pad_out,
    output logic      pad_oe,
    output logic      stat
);
    logic prev_q;
    logic hit;

    // Hold the synchronized level from the previous cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= pin_sync;
    end

    assign hit = (pin_sync != prev_q) && (pin_sync == polarity);

    // Latch the status on a matching edge; an edge wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)   stat <= 1'b0;
        else if (hit) stat <= 1'b1;
        else if (clr) stat <= 1'b0;
    end

    // Derive the pad drive from the mode and the data bit.
    always_comb begin
        unique case (mode)
            PM_PUSHPULL:  begin pad_oe = 1'b1;      pad_out = data_bit; end
            PM_OPENDRAIN: begin pad_oe = ~data_bit; pad_out = 1'b0;     end
            default:      begin pad_oe = 1'b0;      pad_out = 1'b0;     end
        endcase
    end

    // R4: a pull-low pin never drives high
    assert_od_no_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == PM_OPENDRAIN) |-> !(pad_oe && pad_out));
    // R7: the status rises only after a synchronized edge in the chosen direction
    assert_edge_dir_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat) |-> ($past(pin_sync) == $past(polarity)) && ($past(pin_sync, 2) != $past(polarity)));
    // R9: an edge always sets the status, even with a clear pending
    assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> stat);
    // R8: a clear with no edge empties the status
    assert_w1c_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !hit) |=> !stat);
endmodule

// File: rtl/gpio_ctrl.sv
// Top level: register file, synchronizer, per-pin logic and interrupt.
// Assumes a single-cycle write strobe and a combinational read port.
module gpio_ctrl
    import gpio_pkg::*;
#(
    parameter int NUM_GPIO    = 3,
    parameter int NUM_GPO     = 2,
    parameter int DATA_W      = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_we,
    input  logic [1:0]          reg_addr,
    input  logic [DATA_W-1:0]   reg_wdata,
    output logic [DATA_W-1:0]   reg_rdata,
    input  logic [NUM_GPIO-1:0] gpio_in,
    output logic [NUM_GPIO-1:0] gpio_out,
    output logic [NUM_GPIO-1:0] gpio_oe,
    output logic [NUM_GPO-1:0]  gpo_out,
    output logic                irq
);
    localparam int POL_LSB   = 8;
    localparam int EN_LSB    = 12;
    localparam int GPO_LSB   = NUM_GPIO;
    localparam int OUTRB_LSB = 8;

    logic [DATA_W-1:0]   cfg_q;
    logic [NUM_GPIO-1:0] out_q;
    logic [NUM_GPO-1:0]  gpo_q;
    logic [NUM_GPIO-1:0] pin_sync;
    logic [NUM_GPIO-1:0] status;
    logic [NUM_GPIO-1:0] clr_req;
    logic                wr_data;

    assign wr_data = reg_we && (reg_addr == ADDR_DATA);

    // Host writes to the configuration and data registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
            out_q <= '0;
            gpo_q <= '0;
        end else if (reg_we) begin
            if (reg_addr == ADDR_CFG) cfg_q <= reg_wdata;
            if (wr_data) begin
                out_q <= reg_wdata[NUM_GPIO-1:0];
                gpo_q <= reg_wdata[GPO_LSB +: NUM_GPO];
            end
        end
    end

    assign clr_req = (reg_we && reg_addr == ADDR_STATUS) ? reg_wdata[NUM_GPIO-1:0] : '0;

    gpio_sync #(.WIDTH(NUM_GPIO), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .din(gpio_in), .dout(pin_sync)
    );

    generate
        for (genvar i = 0; i < NUM_GPIO; i++) begin : g_pin
            gpio_pin u_pin (
                .clk(clk), .rst_n(rst_n),
                .mode(pin_mode_e'(cfg_q[2*i +: 2])),
                .data_bit(out_q[i]),
                .polarity(cfg_q[POL_LSB+i]),
                .clr(clr_req[i]),
                .pin_sync(pin_sync[i]),
                .pad_out(gpio_out[i]),
                .pad_oe(gpio_oe[i]),
                .stat(status[i])
            );
        end
    endgenerate

    assign gpo_out = gpo_q;
    assign irq     = |(status & cfg_q[EN_LSB +: NUM_GPIO]);

    // Select the read data for the addressed register.
    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            ADDR_CFG: reg_rdata = cfg_q;
            ADDR_DATA: begin
                reg_rdata[NUM_GPIO-1:0]          = pin_sync;
                reg_rdata[GPO_LSB +: NUM_GPO]    = gpo_q;
                reg_rdata[OUTRB_LSB +: NUM_GPIO] = out_q;
            end
            ADDR_STATUS: reg_rdata[NUM_GPIO-1:0] = status;
            default: reg_rdata = '0;
        endcase
    end

    // R5: the output-only pins change only after a data write
    assert_gpo_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(wr_data) && $past(rst_n) |-> $stable(gpo_out));
endmodule

// File: tb/gpio_ctrl_tb.sv
`timescale 1ns/1ps
module gpio_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [2:0]  gpio_in = 3'b000;
    logic [2:0]  gpio_out, gpio_oe;
    logic [1:0]  gpo_out;
    logic        irq;
    int checks = 0;
    int errors = 0;
    logic [31:0] rv;

    always #10 clk = ~clk;

    gpio_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .gpio_in(gpio_in),
        .gpio_out(gpio_out), .gpio_oe(gpio_oe), .gpo_out(gpo_out), .irq(irq)
    );

    // {cfg[5:0], data[2:0], expected oe[2:0], expected out[2:0]}
    localparam logic [14:0] VEC [6] = '{
        {6'b00_01_10, 3'b111, 3'b010, 3'b010},
        {6'b00_01_10, 3'b000, 3'b011, 3'b000},
        {6'b01_01_01, 3'b101, 3'b111, 3'b101},
        {6'b10_10_10, 3'b101, 3'b010, 3'b000},
        {6'b11_11_11, 3'b111, 3'b000, 3'b000},
        {6'b01_10_00, 3'b010, 3'b100, 3'b000}
    };

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] v);
        reg_addr = a; #1; v = reg_rdata;
    endtask

    task automatic edges(input int n);
        for (int k = 0; k < n; k++) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        #(20 * 200000);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        edges(3);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 oe", {29'd0, gpio_oe}, 0);
        chk("R1 out", {29'd0, gpio_out}, 0);
        chk("R1 gpo", {30'd0, gpo_out}, 0);
        chk("R1 irq", {31'd0, irq}, 0);
        rd(2'd2, rv); chk("R1 status", rv, 0);

        // Mode table: R2 input, R3 push-pull, R4 open-drain
        for (int v = 0; v < 6; v++) begin
            wr(2'd0, {26'd0, VEC[v][14:9]});
            wr(2'd1, {29'd0, VEC[v][8:6]});
            chk("R2/R3/R4 oe", {29'd0, gpio_oe}, {29'd0, VEC[v][5:3]});
            chk("R2/R3/R4 out", {29'd0, gpio_out}, {29'd0, VEC[v][2:0]});
        end

        // R5 output-only pins
        wr(2'd1, 32'b10_000);
        chk("R5 gpo", {30'd0, gpo_out}, 2);
        rd(2'd1, rv); chk("R5 readback", {27'd0, rv[4:0]}, 32'b10_000);
        wr(2'd0, 32'h15);
        chk("R5 cfg no effect", {30'd0, gpo_out}, 2);

        // R6 synchronizer latency; all pins push-pull now
        gpio_in = 3'b101;
        edges(1);
        rd(2'd1, rv); chk("R6 one edge", {29'd0, rv[2:0]}, 0);
        edges(1);
        rd(2'd1, rv); chk("R6 two edges", {29'd0, rv[2:0]}, 5);
        edges(1);
        rd(2'd2, rv); chk("R7 wrong direction", rv, 0);

        // R7 rising edge on pin 0, enabled
        wr(2'd0, 32'h1100);
        gpio_in = 3'b100;
        edges(3);
        rd(2'd2, rv); chk("R7 falling ignored", rv, 0);
        gpio_in = 3'b101;
        edges(2);
        rd(2'd2, rv); chk("R7 not yet", rv, 0);
        chk("R10 irq low", {31'd0, irq}, 0);
        edges(1);
        rd(2'd2, rv); chk("R7 set", rv, 1);
        chk("R10 irq high", {31'd0, irq}, 1);

        // R8 clear by writing 1
        wr(2'd2, 32'h0);
        rd(2'd2, rv); chk("R8 write 0 keeps", rv, 1);
        wr(2'd2, 32'h1);
        rd(2'd2, rv); chk("R8 write 1 clears", rv, 0);
        chk("R8 irq low", {31'd0, irq}, 0);

        // R10 latch while disabled: pin 2 falls, falling polarity, no enable
        gpio_in = 3'b001;
        edges(3);
        rd(2'd2, rv); chk("R10 status latched", rv, 4);
        chk("R10 disabled irq", {31'd0, irq}, 0);
        wr(2'd0, 32'h5100);
        chk("R10 enabled irq", {31'd0, irq}, 1);
        wr(2'd2, 32'h4);
        chk("R10 cleared irq", {31'd0, irq}, 0);

        // R9 set wins over same-cycle clear on pin 0
        gpio_in = 3'b000;
        edges(3);
        gpio_in = 3'b001;
        @(posedge clk); @(posedge clk);
        @(negedge clk); reg_we = 1'b1; reg_addr = 2'd2; reg_wdata = 32'h1;
        @(negedge clk); reg_we = 1'b0;
        rd(2'd2, rv); chk("R9 set wins", rv, 1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule